// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block produces the two gate drives for the secondary-side synchronous rectifiers of a phase-shifted full bridge. It watches the four primary bridge gate signals, two per leg, and forms the two diagonal conduction states. Diagonal A is the lead-leg high switch together with the lag-leg low switch. Diagonal B is the lead-leg low switch together with the lag-leg high switch. A 2-bit mode code chooses how these diagonals map onto the rectifier gates. The rectifiers can be held off (diode operation), behave as ideal diodes, or stay on except while the opposite diagonal conducts.

A new mode code takes effect only when the half-cycle boundary strobe is present, so a mode switch always starts at a ZERO or PERIOD boundary of the bridge timebase. Each gate output then passes through a pulse qualifier. The qualifier changes an output only after its wanted level has held for `MIN_PW` clock cycles in a row, so no runt pulse reaches a gate during a mode switch or an abrupt phase-shift step. Rectifier dead time and the load sensing that picks a mode are left to neighbouring logic.

Top module: `sr_gate_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both gate outputs are 0 and the applied mode is the complementary mode (code 2).
- R2: With mode code 0 applied, both gate outputs go to 0 and stay there.
- R3: Mode code 3 behaves exactly like code 0: both gate outputs are held at 0.
- R4: With code 1 (diode emulation), the wanted level of gate A is 1 only while lead_hi=1 and lag_lo=1. The wanted level of gate B is 1 only while lead_lo=1 and lag_hi=1.
- R5: With code 2 (complementary), the wanted level of gate A is 0 only while lead_lo=1 and lag_hi=1. The wanted level of gate B is 0 only while lead_hi=1 and lag_lo=1. At all other times both wanted levels are 1.
- R6: mode_sel is latched on a rising clock edge where edge_stb=1. The latched mode sets the wanted levels from the next edge on. A mode_sel change with edge_stb=0 has no effect on the outputs.
- R7: An output moves to its wanted level on the MIN_PW-th consecutive clock edge at which the wanted level differs from the output. A wanted pulse shorter than MIN_PW cycles never reaches the output.
- R8: Every level of a gate output, once entered, lasts at least MIN_PW clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_hi | input | 1 | Lead-leg high-side bridge gate |
| lead_lo | input | 1 | Lead-leg low-side bridge gate |
| lag_hi | input | 1 | Lag-leg high-side bridge gate |
| lag_lo | input | 1 | Lag-leg low-side bridge gate |
| mode_sel | input | 2 | Requested rectifier mode code |
| edge_stb | input | 1 | Half-cycle boundary strobe (ZERO or PERIOD) |
| sr_gate_a | output | 1 | Rectifier gate paired with diagonal A |
| sr_gate_b | output | 1 | Rectifier gate paired with diagonal B |

## Verification
The hardest case is a diagonal overlap that is just below or just above MIN_PW cycles, arriving close to a mode switch. The stimulus produces it by stepping the phase shift abruptly between small and large values while modes are switched at boundary strobes. This makes overlaps of two, three and several cycles occur under each mode. A separate directed sequence holds the bridge static and injects overlaps of exactly MIN_PW-1 and MIN_PW cycles. Unstrobed mode requests are applied during static intervals, where the outputs plainly show whether the request took effect.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        SRM_OFF  = 2'd0,
        SRM_EMUL = 2'd1,
        SRM_COMP = 2'd2
    } srm_e;

    typedef struct packed {
        logic lead_hi;
        logic lead_lo;
        logic lag_hi;
        logic lag_lo;
    } bridge_t;

    // Unused code 3 falls back to rectifiers off
    function automatic srm_e srm_decode(input logic [1:0] code);
        srm_e m;
        case (code)
            2'd1:    m = SRM_EMUL;
            2'd2:    m = SRM_COMP;
            default: m = SRM_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sr_mode_latch.sv
module sr_mode_latch
    import sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_stb,
    input  logic [1:0] mode_sel,
    output srm_e       act_mode
);

    typedef struct packed {
        srm_e mode;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_stb) begin
            st_d.mode = srm_decode(mode_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= SRM_COMP;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_mode = st_q.mode;

endmodule

// File: rtl/sr_gate_map.sv
module sr_gate_map
    import sr_pkg::*;
#(
    parameter int NUM_GATES = 2
) (
    input  bridge_t              bridge,
    input  srm_e                 mode,
    output logic [NUM_GATES-1:0] want
);

    logic diag_a;
    logic diag_b;
    logic [NUM_GATES-1:0] own_diag;
    logic [NUM_GATES-1:0] opp_diag;

    always_comb begin
        diag_a = bridge.lead_hi & bridge.lag_lo;
        diag_b = bridge.lead_lo & bridge.lag_hi;
    end

    // Gate i pairs with diagonal i, its opposite is the other one
    generate
        for (genvar gi = 0; gi < NUM_GATES; gi++) begin : g_pair
            if (gi % 2 == 0) begin : g_even
                assign own_diag[gi] = diag_a;
                assign opp_diag[gi] = diag_b;
            end else begin : g_odd
                assign own_diag[gi] = diag_b;
                assign opp_diag[gi] = diag_a;
            end
        end
    endgenerate

    always_comb begin
        want = '0;
        for (int i = 0; i < NUM_GATES; i++) begin
            case (mode)
                SRM_EMUL: want[i] = own_diag[i];
                SRM_COMP: want[i] = ~opp_diag[i];
                default:  want[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sr_pulse_filter.sv
module sr_pulse_filter #(
    parameter int MIN_PW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    output logic gate
);

    localparam int CW = (MIN_PW < 2) ? 1 : $clog2(MIN_PW);
    localparam logic [CW-1:0] LAST = CW'(MIN_PW - 1);

    typedef struct packed {
        logic          gate;
        logic [CW-1:0] cnt;
    } pf_st_t;

    pf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (want == st_q.gate) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.gate = want;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate = st_q.gate;

endmodule

// File: rtl/sr_gate_sequencer.sv
module sr_gate_sequencer
    import sr_pkg::*;
#(
    parameter int MIN_PW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lead_hi,
    input  logic       lead_lo,
    input  logic       lag_hi,
    input  logic       lag_lo,
    input  logic [1:0] mode_sel,
    input  logic       edge_stb,
    output logic       sr_gate_a,
    output logic       sr_gate_b
);

    localparam int NUM_GATES = 2;

    bridge_t              bridge;
    srm_e                 act_mode;
    logic [NUM_GATES-1:0] want;
    logic [NUM_GATES-1:0] gate;

    assign bridge = '{lead_hi: lead_hi, lead_lo: lead_lo,
                      lag_hi: lag_hi, lag_lo: lag_lo};

    sr_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_stb (edge_stb),
        .mode_sel (mode_sel),
        .act_mode (act_mode)
    );

    sr_gate_map #(
        .NUM_GATES (NUM_GATES)
    ) u_map (
        .bridge (bridge),
        .mode   (act_mode),
        .want   (want)
    );

    generate
        for (genvar gi = 0; gi < NUM_GATES; gi++) begin : g_filt
            sr_pulse_filter #(
                .MIN_PW (MIN_PW)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .want  (want[gi]),
                .gate  (gate[gi])
            );
        end
    endgenerate

    assign sr_gate_a = gate[0];
    assign sr_gate_b = gate[1];

endmodule

// File: rtl/sr_gate_sequencer_chk.sv
module sr_gate_sequencer_chk
    import sr_pkg::*;
#(
    parameter int MIN_PW = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       edge_stb,
    input logic [1:0] mode_sel,
    input logic       sr_gate_a,
    input logic       sr_gate_b,
    input srm_e       act_mode
);

    int run_a;
    int run_b;
    logic prev_a;
    logic prev_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_a  <= 1;
            run_b  <= 1;
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= sr_gate_a;
            prev_b <= sr_gate_b;
            if (sr_gate_a != prev_a) run_a <= 1;
            else if (run_a < MIN_PW) run_a <= run_a + 1;
            if (sr_gate_b != prev_b) run_b <= 1;
            else if (run_b < MIN_PW) run_b <= run_b + 1;
        end
    end

    // R8
    min_width_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_gate_a != prev_a) |-> (run_a >= MIN_PW));

    // R8
    min_width_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_gate_b != prev_b) |-> (run_b >= MIN_PW));

    // R6
    mode_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_stb |=> $stable(act_mode));

    // R3
    code3_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && mode_sel == 2'd3) |=> (act_mode == SRM_OFF));

    // R2
    off_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == SRM_OFF && !sr_gate_a && !sr_gate_b) |=> (!sr_gate_a && !sr_gate_b));

endmodule

bind sr_gate_sequencer sr_gate_sequencer_chk #(.MIN_PW(MIN_PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_stb  (edge_stb),
    .mode_sel  (mode_sel),
    .sr_gate_a (sr_gate_a),
    .sr_gate_b (sr_gate_b),
    .act_mode  (act_mode)
);

// File: tb/sr_gate_sequencer_bench.sv
`timescale 1ns/1ps
module sr_gate_sequencer_bench;

    localparam int MIN_PW = 4;
    localparam int PER    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lead_hi = 1'b0, lead_lo = 1'b0, lag_hi = 1'b0, lag_lo = 1'b0;
    logic [1:0] mode_sel = 2'd2;
    logic edge_stb = 1'b0;
    logic sr_gate_a, sr_gate_b;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;
    bit done = 0;

    // reference model state
    int  m_code;
    bit  m_a, m_b;
    bit  hist_a[$];
    bit  hist_b[$];

    always #10 clk = ~clk;

    sr_gate_sequencer #(.MIN_PW(MIN_PW)) u_sr_gate_sequencer (
        .clk (clk), .rst_n (rst_n),
        .lead_hi (lead_hi), .lead_lo (lead_lo),
        .lag_hi (lag_hi), .lag_lo (lag_lo),
        .mode_sel (mode_sel), .edge_stb (edge_stb),
        .sr_gate_a (sr_gate_a), .sr_gate_b (sr_gate_b)
    );

    function automatic bit all_differ(bit q[$], bit cur);
        if (q.size() < MIN_PW) return 0;
        foreach (q[i]) if (q[i] == cur) return 0;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_code = 2; m_a = 0; m_b = 0;
            hist_a.delete(); hist_b.delete();
        end else begin
            bit da, db, wa, wb;
            da = lead_hi && lag_lo;
            db = lead_lo && lag_hi;
            case (m_code)
                1: begin wa = da;  wb = db;  end
                2: begin wa = !db; wb = !da; end
                default: begin wa = 0; wb = 0; end
            endcase
            hist_a.push_back(wa); hist_b.push_back(wb);
            if (hist_a.size() > MIN_PW) void'(hist_a.pop_front());
            if (hist_b.size() > MIN_PW) void'(hist_b.pop_front());
            if (all_differ(hist_a, m_a)) m_a = wa;
            if (all_differ(hist_b, m_b)) m_b = wb;
            if (edge_stb) m_code = mode_sel;
        end
    end

    function automatic string mode_tag(int c);
        case (c)
            0: return "R2";
            1: return "R4";
            2: return "R5";
            default: return "R3";
        endcase
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (sr_gate_a !== m_a || sr_gate_b !== m_b) begin
                errors++;
                $display("FAIL %s/R7 t=%0t gates a=%b b=%b expected a=%b b=%b",
                         mode_tag(m_code), $time, sr_gate_a, sr_gate_b, m_a, m_b);
            end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic run_pwm(int cycles, int phase, bit stb_en);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            begin
                int c, cl;
                c  = tcnt % PER;
                cl = (c - phase + PER) % PER;
                lead_hi  = (c >= 1 && c < PER/2);
                lead_lo  = (c >= PER/2 + 1);
                lag_hi   = (cl >= 1 && cl < PER/2);
                lag_lo   = (cl >= PER/2 + 1);
                edge_stb = stb_en && (c == 0 || c == PER/2);
            end
            tcnt++;
        end
    endtask

    task automatic hold(int cycles, logic lh, logic ll, logic gh, logic gl, logic stb);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            lead_hi = lh; lead_lo = ll; lag_hi = gh; lag_lo = gl;
            edge_stb = (k == 0) ? stb : 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low while reset held
        check("R1 reset gate_a", sr_gate_a, 1'b0);
        check("R1 reset gate_b", sr_gate_b, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset gate_a", sr_gate_a, 1'b0);
        // R1: default complementary mode raises both gates on an idle bridge
        hold(MIN_PW + 2, 1, 0, 1, 0, 0);
        check("R1 default mode gate_a", sr_gate_a, 1'b1);
        check("R1 default mode gate_b", sr_gate_b, 1'b1);

        // R5 complementary mode with several phase shifts
        mode_sel = 2'd2;
        run_pwm(200, 12, 1);
        run_pwm(120, 3, 1);
        run_pwm(120, 18, 1);

        // R4 diode emulation, abrupt phase steps
        mode_sel = 2'd1;
        run_pwm(160, 15, 1);
        run_pwm(80, 2, 1);
        run_pwm(80, 19, 1);
        run_pwm(80, 5, 1);

        // R2 off
        mode_sel = 2'd0;
        run_pwm(120, 14, 1);
        check("R2 gate_a", sr_gate_a, 1'b0);
        check("R2 gate_b", sr_gate_b, 1'b0);

        // R3 code 3 behaves as off
        mode_sel = 2'd2;
        run_pwm(100, 10, 1);
        mode_sel = 2'd3;
        run_pwm(120, 10, 1);
        check("R3 gate_a", sr_gate_a, 1'b0);
        check("R3 gate_b", sr_gate_b, 1'b0);

        // R6: unstrobed request ignored
        mode_sel = 2'd2;
        hold(2, 1, 0, 1, 0, 1);
        hold(MIN_PW + 4, 1, 0, 1, 0, 0);
        check("R6 setup gate_a", sr_gate_a, 1'b1);
        mode_sel = 2'd0;
        hold(30, 1, 0, 1, 0, 0);
        check("R6 unstrobed gate_a", sr_gate_a, 1'b1);
        check("R6 unstrobed gate_b", sr_gate_b, 1'b1);
        hold(1, 1, 0, 1, 0, 1);
        hold(MIN_PW + 3, 1, 0, 1, 0, 0);
        check("R6 strobed gate_a", sr_gate_a, 1'b0);
        check("R6 strobed gate_b", sr_gate_b, 1'b0);

        // R7: runt overlap suppressed, full-width overlap passes
        mode_sel = 2'd1;
        hold(1, 1, 0, 1, 0, 1);
        hold(MIN_PW + 2, 1, 0, 1, 0, 0);
        begin
            bit seen = 0;
            for (int k = 0; k < MIN_PW - 1; k++) begin
                @(negedge clk);
                lead_hi = 1; lead_lo = 0; lag_hi = 0; lag_lo = 1;
                seen |= sr_gate_a;
            end
            for (int k = 0; k < MIN_PW + 2; k++) begin
                @(negedge clk);
                lead_hi = 1; lead_lo = 0; lag_hi = 1; lag_lo = 0;
                seen |= sr_gate_a;
            end
            check("R7 runt suppressed", seen, 1'b0);
        end
        hold(MIN_PW, 1, 0, 0, 1, 0);
        @(negedge clk);
        check("R7 full pulse passes", sr_gate_a, 1'b1);
        hold(MIN_PW + 2, 1, 0, 1, 0, 0);

        // mixed mode changes under phase jumps
        for (int r = 0; r < 6; r++) begin
            mode_sel = 2'(r % 3);
            run_pwm(60, (r * 7) % 20, 1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule